// File: doc/BRIEF.md
# Configuration Transaction Engine

This block sits behind a simple register bus and runs one configuration transaction each time software writes the control register with its launch bit set. The word written to the control register is split into five fields: controller, function, site, position and device. Depending on those fields and the direction bit, the engine takes one of four actions:

- It reads or updates an entry in the main-board oscillator table, which has six entries.
- It reads or updates an entry in the daughter-board oscillator table, whose size is set by a parameter.
- It reads a supply voltage.
- It issues a one-cycle shutdown or reboot request.

Each transaction finishes in the cycle after the control write. Its outcome is reported in a two-bit status register. A read result is placed in the data register, and a write takes its value from the data register.

The block is meant for the newest board variant only. When the variant parameter selects an older board, all three registers read as zero, writes to them are ignored, and no request pulses are produced. The daughter-board tables are given as packed parameters holding up to eight 32-bit entries. Entry 0 is in the least significant bits.

Top module: `cfg_xact_engine`

## Requirements
- R1: After reset, the data register at 0xA0, the control register at 0xA4 and the status register at 0xA8 all read zero. The main oscillators hold 50000000, 23750000, 24000000, 24000000, 24000000 and 24000000 for devices 0 to 5. The daughter oscillators hold their parameter entries.
- R2: Control word layout: bit 31 launch, bit 30 write (1) or read (0), bits 29:26 controller, bits 25:20 function, bits 17:16 site, bits 15:12 position, bits 11:0 device. Bits 31, 19 and 18 are never stored and always read as zero.
- R3: A control write with bit 31 set makes the status register read 1 (complete) in the next cycle, or 3 (complete plus error) when the request is not supported.
- R4: A request is supported only if the controller is 0, the position is 0 and the site is 0 (main) or 1 (daughter). Any other combination is an error.
- R5: An oscillator read (function 1) of main devices 0 to 5, or of daughter devices below the daughter oscillator count, loads that entry into the data register. A failed request leaves the data register unchanged.
- R6: An oscillator write (function 1) to a valid device stores the current data register value into that entry. A write to an invalid device changes no entry and is an error.
- R7: A voltage read (function 2) returns 3300000 for main device 0, and the parameter table entry for daughter devices below the voltage count. A voltage write is an error.
- R8: A write with function 8 to main device 0 raises the shutdown output for exactly one cycle, the cycle after the control write. Function 9 does the same on the reboot output. Any other request produces no pulse.
- R9: Writes with function 7 or 11 to main device 0 complete without error and have no effect. Any other function that is not listed above is an error.
- R10: A write to the status register stores only bits 1:0 of the written value.
- R11: When the variant parameter selects an older board, all three registers read zero, writes to them are ignored, and no pulse is produced.
- R12: A control write with bit 31 clear stores the fields only. The status and data registers keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 12 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational from the address |
| shutdown_req | output | 1 | One-cycle shutdown request |
| reboot_req | output | 1 | One-cycle reboot request |

## Verification
Every register result, including the status, the data loaded by a read and the updated oscillator entries, is visible on the read port in the cycle after the write edge. The shutdown and reboot pulses are high during that same cycle and low again one cycle later. Writes are driven on the falling edge and held for one clock. Reads and pulse samples are taken just after the next falling edge, one register stage past the capturing edge. The pulses are sampled a second time one cycle later to confirm they have dropped. The sweeps step through site, device, function, controller and position values on a small daughter table. Each expected status and data value comes from a model of the table contents kept in the bench.

// File: rtl/cfg_xact_engine.sv
module cfg_xact_engine #(
  parameter bit           NEWEST      = 1'b1,
  parameter int           DB_OSC_N    = 2,
  parameter int           DB_VOLT_N   = 2,
  parameter logic [255:0] DB_OSC_INIT = {8{32'd25000000}},
  parameter logic [255:0] DB_VOLT_TAB = {8{32'd1000000}}
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [11:0] bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        shutdown_req,
  output logic        reboot_req
);
  localparam int          MB_N      = 6;
  localparam logic [11:0] A_DATA    = 12'h0A0;
  localparam logic [11:0] A_CTRL    = 12'h0A4;
  localparam logic [11:0] A_STAT    = 12'h0A8;
  localparam logic [31:0] MB_VOLT   = 32'd3300000;
  localparam logic [31:0] CTRL_KEEP = 32'h7FF3_FFFF;

  function automatic logic [31:0] mb_rst(int i);
    return (i == 0) ? 32'd50000000 : (i == 1) ? 32'd23750000 : 32'd24000000;
  endfunction

  logic [31:0] data_q, ctrl_q;
  logic [1:0]  stat_q;
  logic [31:0] mb_osc [MB_N];
  logic [31:0] db_osc [DB_OSC_N];

  wire wr_data = NEWEST && bus_wr && (bus_addr == A_DATA);
  wire wr_ctrl = NEWEST && bus_wr && (bus_addr == A_CTRL);
  wire wr_stat = NEWEST && bus_wr && (bus_addr == A_STAT);
  wire go      = wr_ctrl && bus_wdata[31];
  wire is_wr   = bus_wdata[30];

  wire [5:0]  fn   = bus_wdata[25:20];
  wire [1:0]  site = bus_wdata[17:16];
  wire [11:0] dev  = bus_wdata[11:0];

  wire base_ok = (bus_wdata[29:26] == '0) && (bus_wdata[15:12] == '0) && !site[1];
  wire on_mb   = base_ok && !site[0];
  wire on_db   = base_ok && site[0];
  wire mb0     = on_mb && (dev == '0);

  wire osc_mb_hit = (fn == 6'd1) && on_mb && (dev < 12'(MB_N));
  wire osc_db_hit = (fn == 6'd1) && on_db && (dev < 12'(DB_OSC_N));

  logic [31:0] rd_val;
  logic        rd_hit;
  always_comb begin
    rd_val = '0;
    rd_hit = 1'b0;
    if (fn == 6'd1) begin
      for (int i = 0; i < MB_N; i++)
        if (on_mb && dev == 12'(i)) begin rd_hit = 1'b1; rd_val = mb_osc[i]; end
      for (int i = 0; i < DB_OSC_N; i++)
        if (on_db && dev == 12'(i)) begin rd_hit = 1'b1; rd_val = db_osc[i]; end
    end else if (fn == 6'd2) begin
      if (mb0) begin rd_hit = 1'b1; rd_val = MB_VOLT; end
      for (int i = 0; i < DB_VOLT_N; i++)
        if (on_db && dev == 12'(i)) begin rd_hit = 1'b1; rd_val = DB_VOLT_TAB[i*32 +: 32]; end
    end
  end

  wire wr_hit = osc_mb_hit || osc_db_hit ||
                (mb0 && (fn == 6'd7 || fn == 6'd8 || fn == 6'd9 || fn == 6'd11));
  wire ok = is_wr ? wr_hit : rd_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q       <= '0;
      ctrl_q       <= '0;
      stat_q       <= '0;
      shutdown_req <= 1'b0;
      reboot_req   <= 1'b0;
      for (int i = 0; i < MB_N; i++)     mb_osc[i] <= mb_rst(i);
      for (int i = 0; i < DB_OSC_N; i++) db_osc[i] <= DB_OSC_INIT[i*32 +: 32];
    end else begin
      shutdown_req <= go && is_wr && mb0 && (fn == 6'd8);
      reboot_req   <= go && is_wr && mb0 && (fn == 6'd9);
      if (wr_data) data_q <= bus_wdata;
      if (wr_stat) stat_q <= bus_wdata[1:0];
      if (wr_ctrl) ctrl_q <= bus_wdata & CTRL_KEEP;
      if (go) begin
        stat_q <= {~ok, 1'b1};
        if (!is_wr && ok) data_q <= rd_val;
        for (int i = 0; i < MB_N; i++)
          if (is_wr && osc_mb_hit && dev == 12'(i)) mb_osc[i] <= data_q;
        for (int i = 0; i < DB_OSC_N; i++)
          if (is_wr && osc_db_hit && dev == 12'(i)) db_osc[i] <= data_q;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (NEWEST) begin
      case (bus_addr)
        A_DATA:  bus_rdata = data_q;
        A_CTRL:  bus_rdata = ctrl_q;
        A_STAT:  bus_rdata = {30'b0, stat_q};
        default: bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/cfg_xact_engine_chk.sv
module cfg_xact_engine_chk #(
  parameter bit NEWEST = 1'b1
) (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_wr,
  input logic [11:0] bus_addr,
  input logic [31:0] bus_wdata,
  input logic [31:0] bus_rdata,
  input logic        shutdown_req,
  input logic        reboot_req
);
  wire launch = NEWEST && bus_wr && bus_addr == 12'h0A4 && bus_wdata[31];
  wire mb0_wr = bus_wdata[30] && bus_wdata[29:26] == '0 && bus_wdata[17:16] == '0 &&
                bus_wdata[15:12] == '0 && bus_wdata[11:0] == '0;

  assert_ctrl_masked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 12'h0A4) |-> (bus_rdata[31] == 1'b0 && bus_rdata[19:18] == 2'b00));

  assert_complete_R3: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> (bus_addr != 12'h0A8 || bus_rdata[0]));

  assert_shutdown_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown_req |-> $past(launch && mb0_wr && bus_wdata[25:20] == 6'd8));

  assert_reboot_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    reboot_req |-> $past(launch && mb0_wr && bus_wdata[25:20] == 6'd9));

  assert_pulse_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({shutdown_req, reboot_req}));

  assert_stat_low_bits_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (NEWEST && bus_wr && bus_addr == 12'h0A8) |=>
      (bus_addr != 12'h0A8 || bus_rdata == {30'b0, $past(bus_wdata[1:0])}));

  assert_old_silent_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !NEWEST |-> (bus_rdata == '0 && !shutdown_req && !reboot_req));
endmodule

bind cfg_xact_engine cfg_xact_engine_chk #(.NEWEST(NEWEST)) u_chk (.*);

// File: tb/cfg_xact_engine_bench.sv
module cfg_xact_engine_bench;
  localparam logic [255:0] OSC_T  = {160'b0, 32'd33000000, 32'd45000000, 32'd60000000};
  localparam logic [255:0] VOLT_T = {192'b0, 32'd1200000, 32'd900000};

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n = 1'b0, bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] rdata_new, rdata_old;
  logic        sd_new, rb_new, sd_old, rb_old;
  int checks = 0, fails = 0;
  bit old_pulsed = 1'b0;

  cfg_xact_engine #(.NEWEST(1'b1), .DB_OSC_N(3), .DB_VOLT_N(2), .DB_OSC_INIT(OSC_T), .DB_VOLT_TAB(VOLT_T))
    u_cfg_xact_engine (.clk, .rst_n, .bus_wr, .bus_addr, .bus_wdata,
                       .bus_rdata(rdata_new), .shutdown_req(sd_new), .reboot_req(rb_new));
  cfg_xact_engine #(.NEWEST(1'b0), .DB_OSC_N(3), .DB_VOLT_N(2), .DB_OSC_INIT(OSC_T), .DB_VOLT_TAB(VOLT_T))
    u_old (.clk, .rst_n, .bus_wr, .bus_addr, .bus_wdata,
           .bus_rdata(rdata_old), .shutdown_req(sd_old), .reboot_req(rb_old));

  always @(posedge clk) if (sd_old || rb_old) old_pulsed = 1'b1;

  logic [31:0] mb_m [6];
  logic [31:0] db_m [3];
  logic [31:0] dv_m [2];

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    #1;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] v);
    bus_addr = a; #1; v = rdata_new;
  endtask

  function automatic logic [31:0] cw(bit st, bit w, int c, int f, int s, int p, int d);
    return {st, w, 4'(c), 6'(f), 2'b00, 2'(s), 4'(p), 12'(d)};
  endfunction

  function automatic bit mread(int f, int s, int c, int p, int d, output logic [31:0] v);
    v = '0;
    if (c != 0 || p != 0 || s > 1) return 1'b0;
    if (f == 1 && s == 0 && d < 6) begin v = mb_m[d]; return 1'b1; end
    if (f == 1 && s == 1 && d < 3) begin v = db_m[d]; return 1'b1; end
    if (f == 2 && s == 0 && d == 0) begin v = 32'd3300000; return 1'b1; end
    if (f == 2 && s == 1 && d < 2) begin v = dv_m[d]; return 1'b1; end
    return 1'b0;
  endfunction

  task automatic read_xact(string req, int f, int s, int c, int p, int d, logic [31:0] mark);
    logic [31:0] v, exp;
    bit ok;
    ok = mread(f, s, c, p, d, exp);
    wr(12'h0A0, mark);
    wr(12'h0A4, cw(1, 0, c, f, s, p, d));
    rd(12'h0A8, v); chk(req, v, ok ? 32'd1 : 32'd3);
    rd(12'h0A0, v); chk(req, v, ok ? exp : mark);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    for (int i = 0; i < 6; i++) mb_m[i] = (i == 0) ? 32'd50000000 : (i == 1) ? 32'd23750000 : 32'd24000000;
    for (int i = 0; i < 3; i++) db_m[i] = OSC_T[i*32 +: 32];
    for (int i = 0; i < 2; i++) dv_m[i] = VOLT_T[i*32 +: 32];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    rd(12'h0A0, v); chk("R1 data", v, 0);
    rd(12'h0A4, v); chk("R1 ctrl", v, 0);
    rd(12'h0A8, v); chk("R1 stat", v, 0);

    // R1 R5 R7 R4: read sweep before any oscillator write
    for (int s = 0; s < 4; s++)
      for (int f = 1; f <= 2; f++)
        for (int d = 0; d < 9; d++)
          read_xact(s > 1 ? "R4" : (f == 1 ? "R1/R5" : "R7"), f, s, 0, 0, d, 32'hA500_0000 | 32'(s*100 + f*10 + d));

    // R4: controller and position sweep
    foreach (v[c]) if (c < 16 && (c == 0 || c == 1 || c == 9 || c == 15))
      for (int p = 0; p < 16; p += 5)
        read_xact("R4", 1, 0, c, p, 2, 32'h5A00_0000 | 32'(c*16 + p));

    // R6: oscillator writes
    for (int s = 0; s < 2; s++)
      for (int d = 0; d < 7; d++) begin
        bit ok;
        logic [31:0] val;
        val = 32'd1000 + 32'(s*100 + d);
        ok = (s == 0 && d < 6) || (s == 1 && d < 3);
        wr(12'h0A0, val);
        wr(12'h0A4, cw(1, 1, 0, 1, s, 0, d));
        rd(12'h0A8, v); chk("R6 status", v, ok ? 32'd1 : 32'd3);
        if (ok && s == 0) mb_m[d] = val;
        if (ok && s == 1) db_m[d] = val;
      end
    for (int s = 0; s < 2; s++)
      for (int d = 0; d < 7; d++)
        read_xact("R6", 1, s, 0, 0, d, 32'hC300_0000 | 32'(s*16 + d));

    // R7: voltage is read-only
    wr(12'h0A4, cw(1, 1, 0, 2, 0, 0, 0));
    rd(12'h0A8, v); chk("R7 volt write", v, 3);

    // R8 R9: function sweep on main device 0
    for (int f = 0; f < 16; f++) if (f != 1) begin
      bit ok;
      ok = (f == 7 || f == 8 || f == 9 || f == 11);
      wr(12'h0A0, 32'h0000_1234);
      wr(12'h0A4, cw(1, 1, 0, f, 0, 0, 0));
      chk("R8 shutdown pulse", 32'(sd_new), 32'(f == 8));
      chk("R8 reboot pulse", 32'(rb_new), 32'(f == 9));
      rd(12'h0A8, v); chk("R9 status", v, ok ? 32'd1 : 32'd3);
      rd(12'h0A0, v); chk("R9 data kept", v, 32'h0000_1234);
      @(negedge clk); #1;
      chk("R8 pulse drops", 32'({sd_new, rb_new}), 0);
    end
    wr(12'h0A4, cw(1, 1, 0, 8, 1, 0, 0));
    chk("R8 site1 no pulse", 32'(sd_new), 0);
    rd(12'h0A8, v); chk("R8 site1 err", v, 3);
    wr(12'h0A4, cw(1, 0, 0, 8, 0, 0, 0));
    chk("R8 read no pulse", 32'(sd_new), 0);
    wr(12'h0A4, cw(1, 1, 0, 9, 0, 0, 1));
    chk("R8 dev1 no pulse", 32'(rb_new), 0);
    rd(12'h0A8, v); chk("R8 dev1 err", v, 3);

    // R2 R3 R10 R12
    wr(12'h0A4, 32'hFFFF_FFFF);
    rd(12'h0A4, v); chk("R2 masked store", v, 32'h7FF3_FFFF);
    rd(12'h0A8, v); chk("R3 err status", v, 3);
    wr(12'h0A8, 32'h0000_0000);
    rd(12'h0A8, v); chk("R10 clear", v, 0);
    wr(12'h0A0, 32'hBEEF_0001);
    wr(12'h0A4, 32'h0005_0123);
    rd(12'h0A4, v); chk("R12 store only", v, 32'h0001_0123);
    rd(12'h0A8, v); chk("R12 status kept", v, 0);
    rd(12'h0A0, v); chk("R12 data kept", v, 32'hBEEF_0001);
    wr(12'h0A8, 32'hFFFF_FFFE);
    rd(12'h0A8, v); chk("R10 low bits", v, 2);
    wr(12'h0A8, 32'h0000_0005);
    rd(12'h0A8, v); chk("R10 low bits", v, 1);

    // R11: older variant stays silent
    bus_addr = 12'h0A0; #1; chk("R11 data", rdata_old, 0);
    bus_addr = 12'h0A4; #1; chk("R11 ctrl", rdata_old, 0);
    bus_addr = 12'h0A8; #1; chk("R11 stat", rdata_old, 0);
    chk("R11 no pulse", 32'(old_pulsed), 0);
    finish_run();
  end
endmodule